// File: doc/BRIEF.md
# Programmable Interval Timer with Dual-Rate Prescaler

This block is a 16-bit down-counting interval timer with a byte-wide register port. A free-running prescaler divides the system clock into a fine tick. A five-step subtick counter, driven by that fine tick, marks a coarse tick that runs five times slower. A rate-select bit picks which of the two ticks steps the counter.

Each step decrements the counter, or loads it from a 16-bit reload value when the counter already holds zero. The reload value is written one byte at a time. Every data write also loads the counter at once. When the counter goes from nonzero to zero, a sticky zero-status flag can be set and a level interrupt can be raised.

Two quirks are modelled. Clearing the status works only under certain conditions. Switching from the slow rate to the fast rate in the middle of a coarse period causes one extra step.

Top module: `interval_timer`

## Requirements
- R1: After reset the control read returns 0xE4, the counter reads 0xFFFF (low byte 0xFF, high byte 0xFF), and irq is 0. Enable, rate-select, interrupt-enable and zero-status are 0, the reload value is 0x0000, and the subtick is 0.
- R2: Address 1 is the low data byte and address 2 is the high data byte. Writing either one replaces that byte of the reload value and loads the counter with the whole new reload value in the same cycle. Reads of addresses 1 and 2 return the low and high byte of the counter.
- R3: A read of address 0 returns 0xE4 ORed with: enable in bit 0, zero-status in bit 1, interrupt-enable in bit 3 and rate-select in bit 4. Control writes use the same bit positions, and bit 2 of a write requests a status clear.
- R4: With rate-select at 1 and the timer enabled, the counter steps once every PRESCALE clocks.
- R5: With rate-select at 0 and the timer enabled, the counter steps once every 5*PRESCALE clocks. This happens on the fine tick that wraps the subtick from 4 to 0.
- R6: A step loads the reload value when the counter is 0 and otherwise decrements it by one. While enable is 0, the counter does not step on ticks.
- R7: When the counter changes from nonzero to zero, zero-status is set if enable is 1, and irq is set if interrupt-enable is 1.
- R8: A control write with bit 3 at 0 drives irq to 0 from the next cycle.
- R9: A control write with bit 2 set performs a clear only in two cases: the timer is currently disabled, or the counter is nonzero and the written bit 0 is 0. A clear makes zero-status equal to (counter != 0) and drives irq to 0. In any other case, status and irq are unchanged.
- R10: A control write that changes rate-select from 0 to 1 while the subtick is nonzero performs one step at once, whether or not the timer is enabled. The step uses the R6 and R7 rules and the old field values. The same write with the subtick at 0 performs no step.
- R11: The prescaler and subtick keep running while the timer is disabled. After reset, the first fine tick falls PRESCALE clocks after reset is released.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset, asserted asynchronously, released in step with clk |
| addr | input | 2 | Register select: 0 control, 1 low data, 2 high data |
| wdata | input | 8 | Write data |
| wr_en | input | 1 | Single-cycle write strobe |
| rd_en | input | 1 | Read strobe; rdata is valid in the same cycle |
| rdata | output | 8 | Read data; 0 when rd_en is low |
| irq | output | 1 | Level interrupt, held until it is cleared or masked |

## Verification
The counter is run at both rates, and the spacing between changes is measured in clocks. A mistake in the prescaler or in the subtick wrap point shows up as a wrong period. The reload value 0x0005 is run down through zero and back to 5, which separates a decrement from a reload. A reload value of zero keeps the counter parked at zero, so the status-clear conditions can be probed in each combination: enabled or disabled, counter zero or nonzero. The rate switch is issued once in a cycle where the subtick is 0 and once where it is 1. This tells the mode-switch step apart from an ordinary tick.

// File: rtl/timer_pkg.sv
package timer_pkg;
  localparam logic [1:0] ADDR_CTRL = 2'd0;
  localparam logic [1:0] ADDR_LO   = 2'd1;
  localparam logic [1:0] ADDR_HI   = 2'd2;

  localparam int BIT_EN   = 0;
  localparam int BIT_ZST  = 1;
  localparam int BIT_ZCLR = 2;
  localparam int BIT_IE   = 3;
  localparam int BIT_SEL  = 4;

  localparam logic [7:0] CTRL_FIXED = 8'hE4;
endpackage

// File: rtl/timer_prescaler.sv
module timer_prescaler #(
  parameter int PRESCALE = 400,
  parameter int SUBDIV   = 5
) (
  input  logic clk,
  input  logic rst_n,
  output logic fine_tick,
  output logic coarse_tick,
  output logic sub_nonzero
);
  localparam int PW = (PRESCALE > 2) ? $clog2(PRESCALE) : 1;
  localparam int SW = (SUBDIV > 2) ? $clog2(SUBDIV) : 1;
  localparam logic [PW-1:0] PRE_LAST = PW'(PRESCALE - 1);
  localparam logic [SW-1:0] SUB_LAST = SW'(SUBDIV - 1);

  logic [PW-1:0] pre_q, pre_d;
  logic [SW-1:0] sub_q, sub_d;

  always_comb begin
    fine_tick   = (pre_q == PRE_LAST);
    coarse_tick = fine_tick && (sub_q == SUB_LAST);
    sub_nonzero = (sub_q != '0);
    pre_d = fine_tick ? '0 : pre_q + 1'b1;
    sub_d = sub_q;
    if (fine_tick) sub_d = (sub_q == SUB_LAST) ? '0 : sub_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_q <= '0;
      sub_q <= '0;
    end else begin
      pre_q <= pre_d;
      sub_q <= sub_d;
    end
  end

  // R5: subtick never leaves its 0..SUBDIV-1 range
  assert_sub_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
    sub_q <= SUB_LAST);
  // R11: fine ticks are single-cycle pulses (PRESCALE >= 2)
  assert_tick_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
    fine_tick |=> !fine_tick);
  // R5: subtick only moves on a fine tick
  assert_sub_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !fine_tick |=> $stable(sub_q));
endmodule

// File: rtl/timer_counter.sv
module timer_counter
  import timer_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                ctrl_wr,
  input  logic                lo_wr,
  input  logic                hi_wr,
  input  logic [DATA_W-1:0]   wdata,
  input  logic                fine_tick,
  input  logic                coarse_tick,
  input  logic                sub_nonzero,
  output logic [2*DATA_W-1:0] cnt_q,
  output logic                en_q,
  output logic                sel_q,
  output logic                ie_q,
  output logic                zstat_q,
  output logic                irq_q
);
  localparam int CW = 2 * DATA_W;

  logic [CW-1:0] cnt_d, reload_q, reload_d, step_val;
  logic          en_d, sel_d, ie_d, zstat_d, irq_d;
  logic          quirk_step, tick_step, zero_evt, clr_ok;

  always_comb begin
    step_val   = (cnt_q == '0) ? reload_q : cnt_q - 1'b1;
    quirk_step = ctrl_wr && !sel_q && wdata[BIT_SEL] && sub_nonzero;
    tick_step  = en_q && (sel_q ? fine_tick : coarse_tick);

    reload_d = reload_q;
    if (lo_wr) reload_d[DATA_W-1:0]  = wdata;
    if (hi_wr) reload_d[CW-1:DATA_W] = wdata;

    cnt_d = cnt_q;
    if (lo_wr || hi_wr)             cnt_d = reload_d;
    else if (quirk_step || tick_step) cnt_d = step_val;

    zero_evt = (cnt_q != '0) && (cnt_d == '0);
    clr_ok   = ctrl_wr && wdata[BIT_ZCLR] &&
               (!en_q || ((cnt_q != '0) && !wdata[BIT_EN]));

    zstat_d = zstat_q;
    irq_d   = irq_q;
    if (clr_ok) begin
      zstat_d = (cnt_q != '0);
      irq_d   = 1'b0;
    end
    if (zero_evt && en_q) zstat_d = 1'b1;
    if (zero_evt && ie_q) irq_d   = 1'b1;
    if (ctrl_wr && !wdata[BIT_IE]) irq_d = 1'b0;

    en_d  = ctrl_wr ? wdata[BIT_EN]  : en_q;
    sel_d = ctrl_wr ? wdata[BIT_SEL] : sel_q;
    ie_d  = ctrl_wr ? wdata[BIT_IE]  : ie_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q    <= '1;
      reload_q <= '0;
      en_q     <= 1'b0;
      sel_q    <= 1'b0;
      ie_q     <= 1'b0;
      zstat_q  <= 1'b0;
      irq_q    <= 1'b0;
    end else begin
      cnt_q    <= cnt_d;
      reload_q <= reload_d;
      en_q     <= en_d;
      sel_q    <= sel_d;
      ie_q     <= ie_d;
      zstat_q  <= zstat_d;
      irq_q    <= irq_d;
    end
  end

  // R6: with no enable, no data write and no rate switch, the count holds
  assert_hold_disabled_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!en_q && !lo_wr && !hi_wr && !ctrl_wr) |=> $stable(cnt_q));
  // R7: reaching zero while enabled leaves the zero flag raised
  assert_zero_flag_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (en_q && cnt_q != '0 && !ctrl_wr) |=> (cnt_q != '0 || zstat_q));
  // R8: masking the interrupt drops it in the next cycle
  assert_irq_mask_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_wr && !wdata[BIT_IE]) |=> !irq_q);
  // R9: a clear request while enabled with zero count changes nothing
  assert_no_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_wr && wdata[BIT_ZCLR] && en_q && cnt_q == '0 && wdata[BIT_IE] && ie_q)
      |=> ($stable(zstat_q) && $stable(irq_q)));
endmodule

// File: rtl/interval_timer.sv
module interval_timer
  import timer_pkg::*;
#(
  parameter int PRESCALE = 400,
  parameter int SUBDIV   = 5
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] addr,
  input  logic [7:0] wdata,
  input  logic       wr_en,
  input  logic       rd_en,
  output logic [7:0] rdata,
  output logic       irq
);
  logic        fine_tick, coarse_tick, sub_nonzero;
  logic        ctrl_wr, lo_wr, hi_wr;
  logic [15:0] cnt;
  logic        en, sel, ie, zstat;

  assign ctrl_wr = wr_en && (addr == ADDR_CTRL);
  assign lo_wr   = wr_en && (addr == ADDR_LO);
  assign hi_wr   = wr_en && (addr == ADDR_HI);

  timer_prescaler #(.PRESCALE(PRESCALE), .SUBDIV(SUBDIV)) u_pre (
    .clk        (clk),
    .rst_n      (rst_n),
    .fine_tick  (fine_tick),
    .coarse_tick(coarse_tick),
    .sub_nonzero(sub_nonzero)
  );

  timer_counter #(.DATA_W(8)) u_cnt (
    .clk        (clk),
    .rst_n      (rst_n),
    .ctrl_wr    (ctrl_wr),
    .lo_wr      (lo_wr),
    .hi_wr      (hi_wr),
    .wdata      (wdata),
    .fine_tick  (fine_tick),
    .coarse_tick(coarse_tick),
    .sub_nonzero(sub_nonzero),
    .cnt_q      (cnt),
    .en_q       (en),
    .sel_q      (sel),
    .ie_q       (ie),
    .zstat_q    (zstat),
    .irq_q      (irq)
  );

  always_comb begin
    rdata = '0;
    if (rd_en) begin
      case (addr)
        ADDR_CTRL: begin
          rdata = CTRL_FIXED;
          rdata[BIT_EN]  = en;
          rdata[BIT_ZST] = zstat;
          rdata[BIT_IE]  = ie;
          rdata[BIT_SEL] = sel;
        end
        ADDR_LO: rdata = cnt[7:0];
        ADDR_HI: rdata = cnt[15:8];
        default: rdata = '0;
      endcase
    end
  end

  // R3: constant bits of the control read are always present
  assert_ctrl_fixed_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && addr == ADDR_CTRL) |-> ((rdata & CTRL_FIXED) == CTRL_FIXED));
endmodule

// File: tb/tb_interval_timer.sv
module tb_interval_timer;
  localparam int P = 8;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] addr = '0;
  logic [7:0] wdata = '0;
  logic       wr_en = 1'b0;
  logic       rd_en = 1'b0;
  logic [7:0] rdata;
  logic       irq;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit done = 1'b0;

  interval_timer #(.PRESCALE(P), .SUBDIV(5)) dut (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wdata(wdata),
    .wr_en(wr_en), .rd_en(rd_en), .rdata(rdata), .irq(irq)
  );

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  // starts at a negedge, consumes one posedge
  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    addr = a; rd_en = 1'b1;
    #1 d = rdata;
    rd_en = 1'b0;
  endtask

  task automatic rd_cnt(output int v);
    logic [7:0] lo, hi;
    rd(2'd1, lo);
    rd(2'd2, hi);
    v = {hi, lo};
  endtask

  task automatic wait_change(output int t, output int v);
    int v0, vn;
    rd_cnt(v0);
    vn = v0;
    for (int i = 0; i < 1000 && vn == v0; i++) begin
      @(negedge clk);
      rd_cnt(vn);
    end
    t = cyc;
    v = vn;
  endtask

  task automatic t_reset;
    logic [7:0] d;
    rd(2'd0, d); check("R1/R3 ctrl after reset", d, 8'hE4);
    rd(2'd1, d); check("R1 counter low", d, 8'hFF);
    rd(2'd2, d); check("R1 counter high", d, 8'hFF);
    check("R1 irq", irq, 0);
  endtask

  // must start on the negedge where reset was released
  task automatic t_rate_switch;
    int v;
    logic [7:0] d;
    wr(2'd1, 8'h10);           // edge 1
    wr(2'd2, 8'h00);           // edge 2
    wr(2'd0, 8'h10);           // edge 3, subtick 0
    rd_cnt(v); check("R10 no step with subtick 0", v, 16'h0010);
    wr(2'd0, 8'h00);           // edge 4
    repeat (7) @(negedge clk); // edges 5..11
    wr(2'd0, 8'h10);           // edge 12, subtick 1 while disabled
    rd_cnt(v); check("R10/R11 step on rate switch", v, 16'h000F);
    rd(2'd0, d); check("R3 rate-select bit", d, 8'hF4);
    wr(2'd0, 8'h00);
  endtask

  task automatic t_data;
    int v;
    wr(2'd1, 8'h34);
    rd_cnt(v); check("R2 low write loads counter", v, 16'h0034);
    wr(2'd2, 8'h12);
    rd_cnt(v); check("R2 high write loads counter", v, 16'h1234);
    repeat (100) @(negedge clk);
    rd_cnt(v); check("R6 disabled counter holds", v, 16'h1234);
  endtask

  task automatic t_fast;
    int t1, v1, t2, v2, t, v;
    logic [7:0] d;
    wr(2'd1, 8'h05);
    wr(2'd2, 8'h00);
    wr(2'd0, 8'h19);
    wait_change(t1, v1);
    wait_change(t2, v2);
    check("R4 fast period", t2 - t1, P);
    check("R6 decrement", v2, v1 - 1);
    v = v2;
    for (int i = 0; i < 10 && v != 0; i++) wait_change(t, v);
    check("R6 reached zero", v, 0);
    rd(2'd0, d); check("R7 zero-status set", d[1], 1);
    check("R7 irq set", irq, 1);
    wait_change(t, v);
    check("R6 reload from zero", v, 5);
    wr(2'd0, 8'h11);
    check("R8 irq masked", irq, 0);
    rd(2'd0, d); check("R8 status kept when masking", d, 8'hF7);
  endtask

  task automatic t_slow;
    int t1, t2, t3, v;
    wr(2'd0, 8'h01);
    wait_change(t1, v);
    wait_change(t2, v);
    wait_change(t3, v);
    check("R5 slow period", t3 - t2, 5 * P);
  endtask

  task automatic t_clear;
    logic [7:0] d;
    wr(2'd0, 8'h09);
    wr(2'd1, 8'h07);
    wr(2'd1, 8'h00);           // reload 0: counter parks at 0
    check("R7 irq on write to zero", irq, 1);
    wr(2'd0, 8'h0D);           // enabled, count 0: no clear
    rd(2'd0, d); check("R9 no clear when enabled at zero", d, 8'hEF);
    check("R9 irq kept", irq, 1);
    wr(2'd0, 8'h08);
    wr(2'd0, 8'h0C);           // disabled: clear
    rd(2'd0, d); check("R9 clear while disabled", d, 8'hEC);
    check("R9 irq cleared", irq, 0);
    wr(2'd1, 8'h07);
    wr(2'd1, 8'h00);           // disabled zero event
    rd(2'd0, d); check("R7 no status when disabled", d[1], 0);
    check("R7 irq when disabled", irq, 1);
    wr(2'd1, 8'h07);
    wr(2'd0, 8'h0C);           // clear with nonzero count
    rd(2'd0, d); check("R9 status follows nonzero count", d, 8'hEE);
    check("R9 irq cleared nonzero", irq, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_rate_switch();
    t_reset_after();
    t_data();
    t_fast();
    t_slow();
    t_clear();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  task automatic t_reset_after;
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    t_reset();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule